// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the host-facing configuration front end of a multi-function peripheral controller. The host reaches it through two I/O addresses. One is an index port that picks an internal configuration register. The other is a data port that reads or writes the picked register. Two strap inputs choose one of four base addresses for the pair. The straps are sampled while reset is asserted and are not looked at again until the next reset, so the pair can be moved away from other adapters on the I/O bus.

Behind the port sits one register, the function-enable register at index 00h. Its bits become per-function enable outputs for the parallel port, two UARTs and the floppy controller. Each enable both gates host access and powers the function down; the function keeps its own register contents. Other bits select primary or secondary addresses for the floppy and IDE functions and pick the two-drive or four-drive select encoding. One bit opens the IDE port; while it is clear, the IDE chip-select and buffer-enable lines are forced inactive and the IDE data bit 7 driver is turned off. UART interrupt requests pass straight to their IRQ outputs whatever the enable bits say.

Top module: `cfg_index_port`

## Requirements
- R1: Strap value 00 places the index port at 398h, 01 at 26Eh, 10 at 15Ch and 11 at 2Eh; the data port is the index address plus one. The straps are captured while rst_n is low, and changes after reset is released have no effect.
- R2: A write to the index address loads the 8-bit index register, and a read of the index address returns its value in the same cycle.
- R3: A data-port write while the index is 00h loads the function-enable register, and a data-port read with index 00h returns it.
- R4: With any index other than 00h, data-port reads return 00h and data-port writes leave the function-enable register unchanged.
- R5: Reset clears the index and function-enable registers to 00h, so every enable and select output is 0.
- R6: Function-enable bits 0, 1, 2 and 3 drive func_en[0] (parallel port), func_en[1] (UART1), func_en[2] (UART2) and func_en[3] (floppy) from the clock edge that completes the data write.
- R7: Bit 4 drives fdd_quad (1 = encoded four-drive mode), bit 5 drives fdc_sec and bit 7 drives ide_sec (1 = secondary address).
- R8: Bit 6 drives ide_en. While it is 0, ide_cs_n and ide_buf_n are all 1 and ide_d7_oe is 0. While it is 1, each active-low output is the inverse of its active-high request and ide_d7_oe follows its request.
- R9: uart_irq equals uart_irq_req at all times, regardless of func_en.
- R10: An access to an address outside the selected pair changes no register and returns 00h on io_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap | input | 2 | Base-address strap pins |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational |
| io_hit | output | 1 | Address matches the index or data port |
| func_en | output | 4 | Enables: parallel, UART1, UART2, floppy |
| fdd_quad | output | 1 | Encoded four-drive select mode |
| fdc_sec | output | 1 | Floppy secondary address select |
| ide_sec | output | 1 | IDE secondary address select |
| ide_en | output | 1 | IDE port enabled |
| ide_cs_req | input | 2 | Chip-select requests from the IDE logic, active high |
| ide_buf_req | input | 2 | Buffer-enable requests, active high |
| ide_d7_oe_req | input | 1 | Data bit 7 drive request |
| ide_cs_n | output | 2 | Gated chip selects, active low |
| ide_buf_n | output | 2 | Gated buffer enables, active low |
| ide_d7_oe | output | 1 | Data bit 7 output enable |
| uart_irq_req | input | 2 | UART interrupt requests |
| uart_irq | output | 2 | UART IRQ outputs |

## Verification
Reads are combinational, so io_rdata is due in the same cycle as the address and strobe. The bench samples it one time unit after driving them, with no clock edge in between. Register writes and every output derived from the function-enable register are due one edge after the write strobe. The bench drives on the falling edge, lets one rising edge pass and checks on the next falling edge. The IDE gating and IRQ paths are combinational from their request inputs and are checked a step after the requests change.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] FER_INDEX = 8'h00;
  localparam int B_FDD_QUAD = 4;
  localparam int B_FDC_SEC  = 5;
  localparam int B_IDE_EN   = 6;
  localparam int B_IDE_SEC  = 7;

  // index-port address chosen by the straps; data port is one above
  function automatic logic [15:0] pair_base(input logic [1:0] s);
    case (s)
      2'b00:   return 16'h0398;
      2'b01:   return 16'h026E;
      2'b10:   return 16'h015C;
      default: return 16'h002E;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              idx_hit,
  output logic              data_hit
);
  import cfg_port_pkg::*;
  logic [1:0] strap_q;
  logic [ADDR_W-1:0] base;

  // straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap;
  end

  assign base     = ADDR_W'(pair_base(strap_q));
  assign idx_hit  = (io_addr == base);
  assign data_hit = (io_addr == base + ADDR_W'(1));

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
  p_hit_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idx_hit, data_hit}));
endmodule

// File: rtl/cfg_fer_reg.sv
module cfg_fer_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_idx,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] fer_q,
  output logic [DW-1:0] sel_rdata
);
  import cfg_port_pkg::*;
  logic fer_sel;

  assign fer_sel = (idx_q == DW'(FER_INDEX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      fer_q <= '0;
    end else begin
      if (wr_idx) idx_q <= wdata;
      if (wr_data && fer_sel) fer_q <= wdata;
    end
  end

  assign sel_rdata = fer_sel ? fer_q : '0;

  p_fer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && fer_sel) |=> (fer_q == $past(wdata)));
  p_fer_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_data && fer_sel)) |=> $stable(fer_q));
  p_reset_clear_r5: assert property (@(posedge clk)
    !rst_n |=> (fer_q == '0 && idx_q == '0));
endmodule

// File: rtl/cfg_ide_gate.sv
module cfg_ide_gate #(
  parameter int CS_W = 2
) (
  input  logic            ide_en,
  input  logic [CS_W-1:0] cs_req,
  input  logic [CS_W-1:0] buf_req,
  input  logic            d7_oe_req,
  output logic [CS_W-1:0] cs_n,
  output logic [CS_W-1:0] buf_n,
  output logic            d7_oe
);
  genvar g;
  generate
    for (g = 0; g < CS_W; g++) begin : g_line
      assign cs_n[g]  = ~(ide_en & cs_req[g]);
      assign buf_n[g] = ~(ide_en & buf_req[g]);
    end
  endgenerate
  assign d7_oe = ide_en & d7_oe_req;

  always_comb begin
    if (!ide_en) begin
      p_ide_quiet_r8: assert (&cs_n && &buf_n && !d7_oe);
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int ADDR_W = 16,
  parameter int CS_W   = 2,
  parameter int NUM_UART = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          strap,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic                io_hit,
  output logic [3:0]          func_en,
  output logic                fdd_quad,
  output logic                fdc_sec,
  output logic                ide_sec,
  output logic                ide_en,
  input  logic [CS_W-1:0]     ide_cs_req,
  input  logic [CS_W-1:0]     ide_buf_req,
  input  logic                ide_d7_oe_req,
  output logic [CS_W-1:0]     ide_cs_n,
  output logic [CS_W-1:0]     ide_buf_n,
  output logic                ide_d7_oe,
  input  logic [NUM_UART-1:0] uart_irq_req,
  output logic [NUM_UART-1:0] uart_irq
);
  import cfg_port_pkg::*;
  logic idx_hit, data_hit;
  logic wr_idx, wr_data;
  logic [7:0] idx_q, fer_q, sel_rdata;

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .strap(strap), .io_addr(io_addr),
    .idx_hit(idx_hit), .data_hit(data_hit)
  );

  assign wr_idx  = io_wr & idx_hit;
  assign wr_data = io_wr & data_hit;

  cfg_fer_reg #(.DW(8)) u_fer (
    .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wr_data(wr_data),
    .wdata(io_wdata), .idx_q(idx_q), .fer_q(fer_q), .sel_rdata(sel_rdata)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd && idx_hit)  io_rdata = idx_q;
    if (io_rd && data_hit) io_rdata = sel_rdata;
  end
  assign io_hit = idx_hit | data_hit;

  assign func_en  = fer_q[3:0];
  assign fdd_quad = fer_q[B_FDD_QUAD];
  assign fdc_sec  = fer_q[B_FDC_SEC];
  assign ide_en   = fer_q[B_IDE_EN];
  assign ide_sec  = fer_q[B_IDE_SEC];

  cfg_ide_gate #(.CS_W(CS_W)) u_ide (
    .ide_en(ide_en), .cs_req(ide_cs_req), .buf_req(ide_buf_req),
    .d7_oe_req(ide_d7_oe_req), .cs_n(ide_cs_n), .buf_n(ide_buf_n),
    .d7_oe(ide_d7_oe)
  );

  // interrupts bypass the enable bits on purpose
  assign uart_irq = uart_irq_req;

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_hit) |=> ($stable(fer_q) && $stable(idx_q)));
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q == $past(io_wdata)));
endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] strap = 2'b01;
  logic [15:0] io_addr = '0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic io_hit, fdd_quad, fdc_sec, ide_sec, ide_en, ide_d7_oe;
  logic [3:0] func_en;
  logic [1:0] ide_cs_req = '0, ide_buf_req = '0, ide_cs_n, ide_buf_n;
  logic ide_d7_oe_req = 0;
  logic [1:0] uart_irq_req = '0, uart_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_index_port u_cfg_index_port (.*);

  function automatic logic [15:0] base_of(input logic [1:0] s);
    logic [15:0] t [4] = '{16'h0398, 16'h026E, 16'h015C, 16'h002E};
    return t[s];
  endfunction

  function automatic logic [7:0] outs();
    return {ide_sec, ide_en, fdc_sec, fdd_quad, func_en};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(posedge clk); @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1; #1 d = io_rdata; io_rd = 0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk); rst_n = 0; strap = s;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; strap = ~s;  // later strap changes must be ignored
  endtask

  // {index, data, expected output byte}
  localparam logic [23:0] VEC [7] = '{
    24'h00_0F_0F, 24'h00_30_30, 24'h05_FF_30, 24'h00_C1_C1,
    24'h7F_00_C1, 24'h00_A5_A5, 24'h00_40_40};

  initial begin
    logic [7:0] r;
    logic [15:0] b;
    do_reset(2'b01);
    b = 16'h026E;
    chk("R5 reset outputs", {8'h0, outs()}, 16'h0);
    rd(b, r); chk("R5 reset index", {8'h0, r}, 16'h0);
    rd(b + 1, r); chk("R5 reset fer", {8'h0, r}, 16'h0);

    foreach (VEC[i]) begin
      wr(b, VEC[i][23:16]);
      wr(b + 1, VEC[i][15:8]);
      chk("R6 R7 R3 R4 outputs", {8'h0, outs()}, {8'h0, VEC[i][7:0]});
      rd(b + 1, r);
      chk("R3 R4 data read", {8'h0, r}, {8'h0, (VEC[i][23:16] == 8'h00) ? VEC[i][7:0] : 8'h00});
      rd(b, r);
      chk("R2 index read", {8'h0, r}, {8'h0, VEC[i][23:16]});
    end

    // R8: FER is 40h, IDE open
    ide_cs_req = 2'b01; ide_buf_req = 2'b10; ide_d7_oe_req = 1; #1;
    chk("R8 open", {11'h0, ide_cs_n, ide_buf_n, ide_d7_oe}, {11'h0, 2'b10, 2'b01, 1'b1});
    wr(b, 8'h00); wr(b + 1, 8'h00); #1;
    chk("R8 closed", {11'h0, ide_cs_n, ide_buf_n, ide_d7_oe}, {11'h0, 2'b11, 2'b11, 1'b0});

    // R9: irq passes with UARTs disabled
    uart_irq_req = 2'b10; #1; chk("R9 irq disabled", {14'h0, uart_irq}, 16'h2);
    wr(b + 1, 8'h06); uart_irq_req = 2'b01; #1;
    chk("R9 irq enabled", {14'h0, uart_irq}, 16'h1);

    // R10: foreign address, including other strap bases
    wr(16'h0398, 8'h00); wr(16'h0399, 8'hFF);
    chk("R10 R1 foreign write", {8'h0, outs()}, 16'h06);
    io_addr = 16'h0399; #1; chk("R10 hit", {15'h0, io_hit}, 16'h0);
    rd(16'h0399, r); chk("R10 foreign read", {8'h0, r}, 16'h0);

    // R1: every strap position
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      b = base_of(2'(s));
      wr(b, 8'h00); wr(b + 1, 8'h9A);
      chk("R1 strap base", {8'h0, outs()}, 16'h009A);
      rd(b, r); chk("R1 index at base", {8'h0, r}, 16'h0);
      rd(b + 1, r); chk("R1 data at base+1", {8'h0, r}, 16'h009A);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule